// File: doc/BRIEF.md
# Almost-Flag Offset Programming Sequencer

This block sits in the load-clock domain of a FIFO and holds the two thresholds that the almost-empty and almost-full comparison logic uses. After a reset both thresholds hold a default of 64. In the short window between reset and the first stored word, software or a host can drive the program-enable input low and present a byte on the low eight bits of the write data bus. The first qualifying load-clock edge copies that byte into both thresholds. A second consecutive qualifying edge replaces only the almost-full threshold.

Every edge used for programming must not also store a word, so the block raises a write-inhibit signal, combinationally from program enable and its own state, which the FIFO write path uses to gate the store at that same edge. Once programming ends (program enable released) or a normal word has been written, the sequencer locks and ignores program enable until the next reset. Flag comparison and the storage array live elsewhere.

Top module: `almost_offset_seq`

## Requirements
- R1: Out of reset, with program enable high (inactive), both thresholds read 64 and write-inhibit is low.
- R2: In the idle state with no word yet written, a rising edge with program enable low loads the data byte into both the almost-empty and the almost-full threshold.
- R3: A second consecutive rising edge with program enable still low loads the data byte into the almost-full threshold only; the almost-empty threshold keeps its first value.
- R4: Third and later consecutive edges with program enable low change neither threshold and keep write-inhibit high.
- R5: Write-inhibit is high during the cycle before every edge that is used for programming (program enable low while idle with no word written, or after one or two captures), and low otherwise.
- R6: Once the word-written input is seen high while idle, program enable is ignored until reset: the thresholds do not change and write-inhibit stays low.
- R7: Releasing program enable after one or two captures closes the window: a later low program enable changes nothing and write-inhibit stays low.
- R8: A synchronous low reset returns the sequencer to idle with both thresholds at 64, from any state.
- R9: Each threshold is 8 bits wide and holds any value 0 to 255, including both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_n | input | 1 | Program enable, active low |
| data_byte | input | 8 | Low byte of the write data bus |
| word_written | input | 1 | High once the FIFO has stored at least one word since reset |
| thr_empty | output | 8 | Almost-empty threshold |
| thr_full | output | 8 | Almost-full threshold |
| wr_block | output | 1 | Inhibits the FIFO store at the coming edge |

## Verification
The in-RTL properties check, on every cycle, that a first capture copies the byte into both thresholds, that a second capture moves only the almost-full threshold, that the thresholds sit still once captures are exhausted or the sequencer is locked, that write-inhibit is never raised without program enable, and that reset yields the defaults. Whether the window truly closes after an early release or a first write, and that the defaults survive long runs with writes, only shows across the bench's directed and random multi-edge sequences, which are compared against a cycle model of the sequencer kept in the bench.

// File: rtl/offs_seq_pkg.sv
// Shared types for the almost-flag threshold sequencer.
package offs_seq_pkg;
    // Sequencer states: idle window, one capture taken, two or more taken, locked.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CAP1 = 2'd1,
        SEQ_CAP2 = 2'd2,
        SEQ_LOCK = 2'd3
    } seq_state_t;
endpackage

// File: rtl/offs_seq_ctrl.sv
// Control FSM of the threshold sequencer.
// Decides which edges are programming edges, which thresholds load on them,
// and raises write-inhibit for those edges.
// Assumes word_written is sticky once high until reset and that all inputs
// are synchronous to clk.
module offs_seq_ctrl
    import offs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_n,
    input  logic       word_written,
    output seq_state_t state_q,
    output logic       load_empty,
    output logic       load_full,
    output logic       wr_block
);
    seq_state_t state_d;

    // Load strobes and write-inhibit for the coming edge.
    always_comb begin
        load_empty = 1'b0;
        load_full  = 1'b0;
        wr_block   = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (!prog_n && !word_written) begin
                    load_empty = 1'b1;
                    load_full  = 1'b1;
                    wr_block   = 1'b1;
                end
            end
            SEQ_CAP1: begin
                if (!prog_n) begin
                    load_full = 1'b1;
                    wr_block  = 1'b1;
                end
            end
            SEQ_CAP2: begin
                if (!prog_n) begin
                    wr_block = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                if (word_written)  state_d = SEQ_LOCK;
                else if (!prog_n)  state_d = SEQ_CAP1;
            end
            SEQ_CAP1: state_d = prog_n ? SEQ_LOCK : SEQ_CAP2;
            SEQ_CAP2: state_d = prog_n ? SEQ_LOCK : SEQ_CAP2;
            default:  state_d = SEQ_LOCK;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // R5: inhibit is only ever raised while program enable is low.
    assert_block_needs_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> !prog_n);

    // R6: the locked state is never left without reset.
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOCK) |=> (state_q == SEQ_LOCK));
endmodule

// File: rtl/offs_reg.sv
// One threshold register: loads d on a strobe, resets to a default value.
// Assumes DEF fits in W bits.
module offs_reg #(
    parameter int W   = 8,
    parameter int DEF = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] DEF_V = W'(DEF);

    // Threshold storage with synchronous reset to the default.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= DEF_V;
        else if (load) q <= d;
    end

    // R8: reset always yields the default value.
    assert_reset_default_R8: assert property (@(posedge clk)
        !rst_n |=> (q == DEF_V));
endmodule

// File: rtl/almost_offset_seq.sv
// Almost-flag threshold sequencer (top).
// Captures the almost-empty and almost-full thresholds from the data byte
// in the window between reset and the first stored word, and blocks FIFO
// stores on programming edges. Assumes a single load-clock domain.
module almost_offset_seq
    import offs_seq_pkg::*;
#(
    parameter int THR_W   = 8,
    parameter int THR_DEF = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic [THR_W-1:0] data_byte,
    input  logic             word_written,
    output logic [THR_W-1:0] thr_empty,
    output logic [THR_W-1:0] thr_full,
    output logic             wr_block
);
    localparam int NUM_THR = 2;

    seq_state_t       state_q;
    logic             load_empty;
    logic             load_full;
    logic [NUM_THR-1:0] load_v;
    logic [THR_W-1:0] thr_q [NUM_THR];

    offs_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_n       (prog_n),
        .word_written (word_written),
        .state_q      (state_q),
        .load_empty   (load_empty),
        .load_full    (load_full),
        .wr_block     (wr_block)
    );

    // Strobe vector: index 0 is almost-empty, index 1 almost-full.
    always_comb begin
        load_v = {load_full, load_empty};
    end

    for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
        offs_reg #(.W(THR_W), .DEF(THR_DEF)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_v[gi]),
            .d     (data_byte),
            .q     (thr_q[gi])
        );
    end

    assign thr_empty = thr_q[0];
    assign thr_full  = thr_q[1];

    // R2: first capture copies the byte into both thresholds.
    assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !prog_n && !word_written)
        |=> (thr_empty == $past(data_byte) && thr_full == $past(data_byte)));

    // R3: second capture moves only the almost-full threshold.
    assert_second_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_CAP1 && !prog_n)
        |=> (thr_empty == $past(thr_empty) && thr_full == $past(data_byte)));

    // R4: after two captures nothing moves.
    assert_hold_after_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_CAP2) |=> ($stable(thr_empty) && $stable(thr_full)));

    // R6, R7: locked thresholds stay put and stores are never inhibited.
    assert_locked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOCK) |=> ($stable(thr_empty) && $stable(thr_full) && !wr_block));

    // R5: an inhibited edge always moves the sequencer out of idle.
    assert_block_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |=> (state_q != SEQ_IDLE));
endmodule

// File: tb/almost_offset_seq_tb.sv
module almost_offset_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_n = 1'b1;
    logic [7:0] data_byte = 8'h00;
    logic       word_written = 1'b0;
    logic [7:0] thr_empty, thr_full;
    logic       wr_block;

    int checks = 0;
    int errors = 0;

    // Bench model: 0 idle, 1 one capture, 2 two+, 3 locked.
    int         m_st = 0;
    logic [7:0] m_x = 8'd64;
    logic [7:0] m_y = 8'd64;

    almost_offset_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_n       (prog_n),
        .data_byte    (data_byte),
        .word_written (word_written),
        .thr_empty    (thr_empty),
        .thr_full     (thr_full),
        .wr_block     (wr_block)
    );

    always #10 clk = ~clk;

    function automatic logic exp_block(int st, logic p, logic ww);
        return !p && ((st == 0 && !ww) || st == 1 || st == 2);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Update the model for one rising edge.
    task automatic model_edge(logic p, logic [7:0] d, logic ww);
        case (m_st)
            0: if (ww) m_st = 3; else if (!p) begin m_x = d; m_y = d; m_st = 1; end
            1: if (!p) begin m_y = d; m_st = 2; end else m_st = 3;
            2: if (p) m_st = 3;
            default: m_st = 3;
        endcase
    endtask

    // One load-clock cycle with checks before and after the edge.
    task automatic step(string req, logic p, logic [7:0] d, logic ww);
        @(negedge clk);
        prog_n = p; data_byte = d; word_written = ww;
        #2;
        chk(req, "wr_block", int'(wr_block), int'(exp_block(m_st, p, ww)));
        @(posedge clk);
        model_edge(p, d, ww);
        #2;
        chk(req, "thr_empty", int'(thr_empty), int'(m_x));
        chk(req, "thr_full", int'(thr_full), int'(m_y));
    endtask

    task automatic do_reset(string req);
        @(negedge clk);
        rst_n = 1'b0; prog_n = 1'b1; word_written = 1'b0;
        @(posedge clk); @(posedge clk);
        #2;
        m_st = 0; m_x = 8'd64; m_y = 8'd64;
        chk(req, "thr_empty after reset", int'(thr_empty), 64);
        chk(req, "thr_full after reset", int'(thr_full), 64);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: defaults out of reset, no inhibit.
        do_reset("R1");
        #2;
        chk("R1", "wr_block idle", int'(wr_block), 0);
        // R1: default-only path with writes.
        step("R1", 1'b1, 8'h11, 1'b0);
        step("R1", 1'b1, 8'h22, 1'b1);
        step("R6", 1'b0, 8'h33, 1'b1);
        step("R6", 1'b0, 8'h44, 1'b1);
        // R8: reset from locked.
        do_reset("R8");
        // R2: single capture, then R7 window closed.
        step("R2", 1'b0, 8'h12, 1'b0);
        step("R7", 1'b1, 8'h99, 1'b0);
        step("R7", 1'b0, 8'h77, 1'b0);
        chk("R2", "thr_empty single", int'(thr_empty), 8'h12);
        do_reset("R8");
        // R3: double capture with different values; R4 third edge.
        step("R3", 1'b0, 8'h05, 1'b0);
        step("R3", 1'b0, 8'hF0, 1'b0);
        chk("R3", "thr_empty keeps first", int'(thr_empty), 8'h05);
        chk("R3", "thr_full second", int'(thr_full), 8'hF0);
        step("R4", 1'b0, 8'hAA, 1'b0);
        step("R4", 1'b0, 8'hBB, 1'b0);
        step("R7", 1'b1, 8'hCC, 1'b0);
        step("R7", 1'b0, 8'hDD, 1'b0);
        do_reset("R8");
        // R9: extremes.
        step("R9", 1'b0, 8'hFF, 1'b0);
        step("R9", 1'b0, 8'h00, 1'b0);
        chk("R9", "thr_empty max", int'(thr_empty), 255);
        chk("R9", "thr_full min", int'(thr_full), 0);
        do_reset("R8");
        // R6: first write then attempted programming.
        step("R6", 1'b1, 8'h01, 1'b1);
        step("R6", 1'b0, 8'h3C, 1'b1);
        step("R6", 1'b0, 8'h3D, 1'b1);
        chk("R6", "thr_empty after lock", int'(thr_empty), 64);
        // R5 and all: constrained random rounds.
        for (int r = 0; r < 60; r++) begin
            logic ww;
            do_reset("R8");
            ww = 1'b0;
            for (int k = 0; k < 12; k++) begin
                logic p;
                p = ($urandom_range(0, 2) != 0) ? 1'b0 : 1'b1;
                if (k > 2 && $urandom_range(0, 5) == 0) ww = 1'b1;
                step("R5", p, 8'($urandom), ww);
            end
        end
        finish_run();
    end
endmodule